// File: doc/BRIEF.md
# Register Busy-Bit Scoreboard

This block detects read-after-write hazards in an in-order pipeline. It keeps one busy flag for each architectural register. It does not compare register numbers against every pipeline stage. When an instruction leaves decode and it will write a register, the flag for that register is raised. When the writing instruction reaches the final pipeline register before write-back, its retire port lowers the flag again. While either source register of the instruction sitting in decode is flagged, that instruction is held.

The hold drives three controls that the surrounding pipeline applies directly:

- The program counter is frozen.
- The fetch/decode register is frozen.
- The decode/execute register is cleared, so that a bubble flows down the pipe.

An instruction that is held does not claim its destination. It claims it later, in the cycle in which it actually issues.

The flags are registered. A set or a clear requested in one cycle becomes visible to decode in the next cycle. Register 0 is a constant register and is never flagged.

Top module: `busy_scoreboard`

## Requirements
- R1: While reset is asserted, and after it is released, every busy flag is clear. In that state no pair of source numbers produces a stall.
- R2: The destination register is flagged busy from the next cycle onward when all three of these hold: `iss_vld` is 1, `stall` is 0, and `iss_dst` is non-zero.
- R3: `stall` is 1 in the same cycle whenever the register named by `dec_src_a` or by `dec_src_b` is flagged busy. Otherwise `stall` is 0.
- R4: While `stall` is 1, `pc_en` is 0, `ifid_en` is 0 and `idex_clr` is 1. While `stall` is 0, they are 1, 1 and 0.
- R5: An issue request made in a cycle in which `stall` is 1 flags no register.
- R6: When `ret_vld` is 1, the register named by `ret_dst` is no longer busy from the next cycle onward, unless R7 applies.
- R7: If an accepted issue and a retire name the same register in the same cycle, that register stays busy.
- R8: Register 0 is never flagged. Issue or retire requests that name it change nothing, and reading it never stalls.
- R9: When `iss_vld` is 0, `iss_dst` has no effect. When `ret_vld` is 0, `ret_dst` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_src_a | input | IDX_W | First source register number of the instruction in decode |
| dec_src_b | input | IDX_W | Second source register number of the instruction in decode |
| iss_vld | input | 1 | The decode instruction writes a register |
| iss_dst | input | IDX_W | Destination register number of the decode instruction |
| ret_vld | input | 1 | The instruction in the last pipeline register writes a register |
| ret_dst | input | IDX_W | Destination register number of that retiring instruction |
| stall | output | 1 | Decode must hold |
| pc_en | output | 1 | Program counter write enable |
| ifid_en | output | 1 | Fetch/decode register write enable |
| idex_clr | output | 1 | Clear the decode/execute register (insert a bubble) |

## Verification
The bench flags each register in turn and sweeps every pair of source numbers against it. A design that mis-indexes its table, or that looks at only one source, stalls on the wrong pairs.

The bench then targets several corner cases:

- **Issue while stalled.** A design that let a held instruction claim its destination would stall a later reader of that register.
- **Set and clear in the same cycle.** A design in which the clear wins would let a dependent instruction through.
- **Register 0 and dropped valid flags.** A design that flags register 0 would stall reads of the constant register. A design that ignores a valid flag would set or clear flags that should not move.

A long pseudo-random stream closes the run. It mixes overlapping issues and retires so that several flags are live at once.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef struct packed {
        logic stall;
        logic pc_en;
        logic ifid_en;
        logic idex_clr;
    } pipe_ctl_t;

    localparam int unsigned NUM_SRCS = 2;

endpackage

// File: rtl/sb_busy_table.sv
module sb_busy_table #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] busy
);

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_flag
            if (g == 0) begin : g_zero
                // constant register: never tracked
                assign busy[g] = 1'b0;
            end else begin : g_live
                logic hit_set;
                logic hit_clr;
                logic flag_q;

                assign hit_set = set_en && (set_idx == IDX_W'(g));
                assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        flag_q <= 1'b0;
                    end else if (hit_set) begin
                        // set has priority over a coincident clear
                        flag_q <= 1'b1;
                    end else if (hit_clr) begin
                        flag_q <= 1'b0;
                    end
                end

                assign busy[g] = flag_q;
            end
        end
    endgenerate

endmodule

// File: rtl/sb_src_check.sv
module sb_src_check #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS),
    parameter int unsigned N_SRC    = sb_pkg::NUM_SRCS
) (
    input  logic [NUM_REGS-1:0]         busy,
    input  logic [N_SRC-1:0][IDX_W-1:0] srcs,
    output logic                        hazard
);

    logic [N_SRC-1:0] src_hit;

    genvar s;
    generate
        for (s = 0; s < N_SRC; s++) begin : g_src
            assign src_hit[s] = busy[srcs[s]];
        end
    endgenerate

    assign hazard = |src_hit;

endmodule

// File: rtl/sb_stall_ctl.sv
module sb_stall_ctl (
    input  logic             hazard,
    input  logic             iss_vld,
    output sb_pkg::pipe_ctl_t ctl,
    output logic             claim
);

    always_comb begin
        ctl.stall    = hazard;
        ctl.pc_en    = !hazard;
        ctl.ifid_en  = !hazard;
        ctl.idex_clr = hazard;
        // a held instruction never claims its destination
        claim        = iss_vld && !hazard;
    end

endmodule

// File: rtl/busy_scoreboard.sv
module busy_scoreboard #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] dec_src_a,
    input  logic [IDX_W-1:0] dec_src_b,
    input  logic             iss_vld,
    input  logic [IDX_W-1:0] iss_dst,
    input  logic             ret_vld,
    input  logic [IDX_W-1:0] ret_dst,
    output logic             stall,
    output logic             pc_en,
    output logic             ifid_en,
    output logic             idex_clr
);

    logic [NUM_REGS-1:0]                          busy_q;
    logic [sb_pkg::NUM_SRCS-1:0][IDX_W-1:0]       src_vec;
    logic                                         hazard;
    logic                                         claim;
    sb_pkg::pipe_ctl_t                            ctl;

    assign src_vec[0] = dec_src_a;
    assign src_vec[1] = dec_src_b;

    sb_busy_table #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (claim),
        .set_idx (iss_dst),
        .clr_en  (ret_vld),
        .clr_idx (ret_dst),
        .busy    (busy_q)
    );

    sb_src_check #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .N_SRC(sb_pkg::NUM_SRCS)) u_check (
        .busy   (busy_q),
        .srcs   (src_vec),
        .hazard (hazard)
    );

    sb_stall_ctl u_ctl (
        .hazard  (hazard),
        .iss_vld (iss_vld),
        .ctl     (ctl),
        .claim   (claim)
    );

    assign stall    = ctl.stall;
    assign pc_en    = ctl.pc_en;
    assign ifid_en  = ctl.ifid_en;
    assign idex_clr = ctl.idex_clr;

endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [IDX_W-1:0]    dec_src_a,
    input logic [IDX_W-1:0]    dec_src_b,
    input logic                iss_vld,
    input logic [IDX_W-1:0]    iss_dst,
    input logic                ret_vld,
    input logic [IDX_W-1:0]    ret_dst,
    input logic                stall,
    input logic                pc_en,
    input logic                ifid_en,
    input logic                idex_clr,
    input logic [NUM_REGS-1:0] busy
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> busy == '0);

    // R2
    issue_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld && !stall && iss_dst != '0 |=> busy[$past(iss_dst)]);

    // R3
    src_busy_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[dec_src_a] || busy[dec_src_b]) |-> stall);

    // R4
    stall_controls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!pc_en && !ifid_en && idex_clr));

    // R5
    held_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !ret_vld |=> $stable(busy));

    // R6
    retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld && ret_dst != '0 && !(iss_vld && !stall && iss_dst == ret_dst)
        |=> !busy[$past(ret_dst)]);

    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld && iss_vld && !stall && iss_dst == ret_dst && iss_dst != '0
        |=> busy[$past(iss_dst)]);

    // R8
    zero_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[0]);

endmodule

bind busy_scoreboard sb_scoreboard_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_sb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .iss_vld   (iss_vld),
    .iss_dst   (iss_dst),
    .ret_vld   (ret_vld),
    .ret_dst   (ret_dst),
    .stall     (stall),
    .pc_en     (pc_en),
    .ifid_en   (ifid_en),
    .idex_clr  (idex_clr),
    .busy      (busy_q)
);

// File: tb/test_busy_scoreboard.sv
module test_busy_scoreboard;

    localparam int unsigned NR = 8;
    localparam int unsigned IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] dec_src_a = '0;
    logic [IW-1:0] dec_src_b = '0;
    logic          iss_vld = 1'b0;
    logic [IW-1:0] iss_dst = '0;
    logic          ret_vld = 1'b0;
    logic [IW-1:0] ret_dst = '0;
    logic          stall, pc_en, ifid_en, idex_clr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [NR-1:0] model = '0;

    always #10 clk = ~clk;

    busy_scoreboard #(.NUM_REGS(NR), .IDX_W(IW)) i_busy_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .iss_vld(iss_vld), .iss_dst(iss_dst),
        .ret_vld(ret_vld), .ret_dst(ret_dst),
        .stall(stall), .pc_en(pc_en), .ifid_en(ifid_en), .idex_clr(idex_clr)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive, sample combinational outputs, then advance the model
    task automatic step(input logic [IW-1:0] a, input logic [IW-1:0] b,
                        input logic iv, input logic [IW-1:0] id,
                        input logic rv, input logic [IW-1:0] rd,
                        input string tag);
        logic exp_st;
        @(negedge clk);
        dec_src_a = a; dec_src_b = b;
        iss_vld = iv; iss_dst = id; ret_vld = rv; ret_dst = rd;
        #5;
        exp_st = model[a] | model[b];
        check(stall, exp_st, tag);
        check(pc_en, !exp_st, "R4");
        check(ifid_en, !exp_st, "R4");
        check(idex_clr, exp_st, "R4");
        @(posedge clk);
        if (rv && rd != '0) model[rd] = 1'b0;
        if (iv && !exp_st && id != '0) model[id] = 1'b1;
    endtask

    task automatic idle(input string tag);
        step('0, '0, 1'b0, '0, 1'b0, '0, tag);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        // R1: outputs during reset, then a full sweep after release
        @(negedge clk);
        check(stall, 1'b0, "R1");
        rst_n = 1'b1;
        for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++)
                step(IW'(a), IW'(b), 1'b0, '0, 1'b0, '0, "R1");

        // R2 / R3 / R6: flag each register, sweep all source pairs, retire
        for (int r = 1; r < NR; r++) begin
            step('0, '0, 1'b1, IW'(r), 1'b0, '0, "R2");
            for (int a = 0; a < NR; a++)
                for (int b = 0; b < NR; b++)
                    step(IW'(a), IW'(b), 1'b0, '0, 1'b0, '0, "R3");
            step('0, '0, 1'b0, '0, 1'b1, IW'(r), "R6");
            step(IW'(r), IW'(r), 1'b0, '0, 1'b0, '0, "R6");
        end

        // R5: held instruction must not claim its destination
        step('0, '0, 1'b1, 3'd3, 1'b0, '0, "R2");
        step(3'd3, '0, 1'b1, 3'd5, 1'b0, '0, "R5");
        step('0, 3'd5, 1'b0, '0, 1'b0, '0, "R5");
        step('0, '0, 1'b0, '0, 1'b1, 3'd3, "R6");
        step(3'd5, 3'd3, 1'b0, '0, 1'b0, '0, "R5");

        // R7: coincident set and clear on the same register
        step('0, '0, 1'b1, 3'd2, 1'b0, '0, "R2");
        step('0, '0, 1'b1, 3'd2, 1'b1, 3'd2, "R7");
        step(3'd2, '0, 1'b0, '0, 1'b0, '0, "R7");
        step('0, '0, 1'b0, '0, 1'b1, 3'd2, "R6");
        step('0, 3'd2, 1'b0, '0, 1'b0, '0, "R6");

        // R8: register 0 requests change nothing
        step('0, '0, 1'b1, '0, 1'b0, '0, "R8");
        step('0, '0, 1'b0, '0, 1'b1, '0, "R8");
        step('0, '0, 1'b0, '0, 1'b0, '0, "R8");

        // R9: dropped valid flags
        step('0, '0, 1'b0, 3'd4, 1'b0, '0, "R9");
        step(3'd4, '0, 1'b0, '0, 1'b0, '0, "R9");
        step('0, '0, 1'b1, 3'd6, 1'b0, '0, "R2");
        step('0, '0, 1'b0, '0, 1'b0, 3'd6, "R9");
        step('0, 3'd6, 1'b0, '0, 1'b0, '0, "R9");
        step('0, '0, 1'b0, '0, 1'b1, 3'd6, "R6");

        // mixed stream with several live flags
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2:0], lfsr[5:3], lfsr[6], lfsr[9:7], lfsr[10] | lfsr[11], lfsr[14:12], "R3");
        end
        idle("R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule